// File: doc/BRIEF.md
# Character-Fetch Video Serializer

This block sits on the path between a Z80-style processor and its memories and turns display-file bytes into a pixel stream. Display-file bytes are read through processor opcode fetches in the upper half of the address space. When such a fetch returns a character code, the block keeps a copy of the code and puts a zero byte (a no-operation) on the processor's data bus. The processor therefore only advances its program counter and its refresh counter. A byte with the line-end bit set is passed through unchanged, so the processor halts at the end of a text line.

In the refresh cycle that follows a captured fetch, the block forms a glyph-ROM address from three parts: the upper refresh address bits (the processor's vector register), the six-bit character code and a three-bit scan-row counter. It loads the returned byte into a shift register. The shift register runs on the pixel clock, which is twice the processor clock, so it sends out eight pixels per four-T-state fetch. Bit 7 of the code can invert the character. A horizontal-line tick advances the row counter, and a vertical-sync clear resets it.

Top module: `cfv_serializer`

## Requirements
- R1: During an opcode fetch (bus_fetch=1) with bus_addr[15]=1 and mem_data[6]=0, cpu_data is 8'h00 in the same cycle.
- R2: During an opcode fetch with bus_addr[15]=1 and mem_data[6]=1 (for example 8'h76), cpu_data equals mem_data and no pixels are produced for that byte.
- R3: When bus_fetch=0, or during a fetch with bus_addr[15]=0, cpu_data equals mem_data and nothing is captured.
- R4: While bus_refresh=1 and a capture is pending, rom_addr[12:9]=bus_addr[12:9], rom_addr[8:3]=code[5:0] and rom_addr[2:0]=the row count.
- R5: The row count starts at 0, rises by one (mod 8) on each clock with hsync_tick=1, and is 0 after any clock with row_clear=1, which takes priority over hsync_tick.
- R6: On the clock edge that samples the first refresh cycle after a capture, rom_data is loaded. From the next cycle on, pixel_valid=1 for eight cycles and video carries the glyph bits 7 down to 0, one per pixel clock.
- R7: When bit 7 of the captured code is 1, all eight pixels of that character are inverted.
- R8: With no glyph being shifted, pixel_valid=0 and video=0.
- R9: A capture is dropped by any later fetch that captures nothing, and each capture gives at most one glyph load, however long the refresh lasts.
- R10: After reset the row count is 0, nothing is pending, and video and pixel_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, twice the processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_fetch | input | 1 | Processor opcode-fetch cycle active |
| bus_refresh | input | 1 | Processor refresh cycle active |
| bus_addr | input | 16 | Processor address bus |
| mem_data | input | 8 | Byte returned by memory |
| cpu_data | output | 8 | Byte presented to the processor |
| rom_addr | output | 13 | Glyph ROM address |
| rom_data | input | 8 | Glyph ROM byte |
| hsync_tick | input | 1 | One-cycle pulse per raster line |
| row_clear | input | 1 | Synchronous row-counter clear at vertical sync |
| video | output | 1 | Pixel value |
| pixel_valid | output | 1 | High while a glyph pixel is on video |

## Verification
The assertions assume that fetch and refresh cycles never overlap. They also assume that every bus phase lasts a whole number of pixel clocks with the inputs held steady. The stimulus builds each character slot as four pixel clocks of fetch followed by four of refresh. It only adds deliberately odd orderings, such as dropped or repeated refreshes and lower-half fetches, that keep those two conditions. Row-counter checks read the row through rom_addr[2:0], so the stimulus keeps a refresh-with-pending window reachable after hsync and clear events.

// File: rtl/cfv_pkg.sv
package cfv_pkg;
   localparam int unsigned CFV_ADDR_W    = 16;
   localparam int unsigned CFV_DATA_W    = 8;
   localparam int unsigned CFV_CODE_BITS = 6;
   localparam int unsigned CFV_ROW_BITS  = 3;
   localparam int unsigned CFV_BASE_BITS = 4;
   localparam int unsigned CFV_HALT_BIT  = 6;

   typedef enum logic [1:0] {
      STEAL_PASS = 2'd0,
      STEAL_NOP  = 2'd1,
      STEAL_HALT = 2'd2
   } steal_kind_e;

   function automatic steal_kind_e classify(input logic fetch, input logic window,
                                            input logic halt_bit);
      if (!(fetch && window)) return STEAL_PASS;
      if (halt_bit) return STEAL_HALT;
      return STEAL_NOP;
   endfunction
endpackage

// File: rtl/cfv_fetch_steal.sv
module cfv_fetch_steal #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned HALT_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_fetch,
   input  logic              bus_refresh,
   input  logic              window,
   input  logic [DATA_W-1:0] mem_data,
   output logic [DATA_W-1:0] cpu_data,
   output logic [DATA_W-1:0] code_q,
   output logic              load
);
   import cfv_pkg::*;

   steal_kind_e kind;
   logic        pend_q;

   assign kind = classify(bus_fetch, window, mem_data[HALT_BIT]);

   always_comb begin
      cpu_data = mem_data;
      if (kind == STEAL_NOP) cpu_data = '0;
   end

   assign load = bus_refresh && pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         code_q <= '0;
      end else if (bus_fetch) begin
         if (kind == STEAL_NOP) begin
            code_q <= mem_data;
            pend_q <= 1'b1;
         end else begin
            pend_q <= 1'b0;
         end
      end else if (load) begin
         pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/cfv_row_count.sv
module cfv_row_count #(
   parameter int unsigned ROW_BITS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hsync_tick,
   input  logic                row_clear,
   output logic [ROW_BITS-1:0] row_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          row_q <= '0;
      else if (row_clear)  row_q <= '0;
      else if (hsync_tick) row_q <= row_q + 1'b1;
   end
endmodule

// File: rtl/cfv_shifter.sv
module cfv_shifter #(
   parameter int unsigned PIX_W     = 8,
   parameter bit          INVERT_EN = 1'b1,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PIX_W-1:0] glyph,
   input  logic             inv,
   output logic             video,
   output logic             pixel_valid
);
   localparam int unsigned CNT_W = $clog2(PIX_W + 1);

   logic [PIX_W-1:0] sh_q;
   logic [CNT_W-1:0] cnt_q;
   logic             inv_q;
   logic             raw_pix;

   generate
      if (MSB_FIRST) begin : g_msb
         assign raw_pix = sh_q[PIX_W-1];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            sh_q <= '0;
            else if (load)         sh_q <= glyph;
            else if (cnt_q != '0)  sh_q <= {sh_q[PIX_W-2:0], 1'b0};
         end
      end else begin : g_lsb
         assign raw_pix = sh_q[0];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            sh_q <= '0;
            else if (load)         sh_q <= glyph;
            else if (cnt_q != '0)  sh_q <= {1'b0, sh_q[PIX_W-1:1]};
         end
      end

      if (INVERT_EN) begin : g_inv
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    inv_q <= 1'b0;
            else if (load) inv_q <= inv;
         end
      end else begin : g_noinv
         logic unused_inv;
         assign unused_inv = inv;
         assign inv_q = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (load)        cnt_q <= CNT_W'(PIX_W);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign pixel_valid = (cnt_q != '0);
   assign video       = pixel_valid && (raw_pix ^ inv_q);
endmodule

// File: rtl/cfv_serializer.sv
module cfv_serializer #(
   parameter int unsigned ADDR_W    = cfv_pkg::CFV_ADDR_W,
   parameter int unsigned DATA_W    = cfv_pkg::CFV_DATA_W,
   parameter int unsigned CODE_BITS = cfv_pkg::CFV_CODE_BITS,
   parameter int unsigned ROW_BITS  = cfv_pkg::CFV_ROW_BITS,
   parameter int unsigned BASE_BITS = cfv_pkg::CFV_BASE_BITS,
   parameter int unsigned HALT_BIT  = cfv_pkg::CFV_HALT_BIT,
   parameter bit          INVERT_EN = 1'b1,
   parameter bit          MSB_FIRST = 1'b1,
   localparam int unsigned ROM_AW   = BASE_BITS + CODE_BITS + ROW_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_fetch,
   input  logic              bus_refresh,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] mem_data,
   output logic [DATA_W-1:0] cpu_data,
   output logic [ROM_AW-1:0] rom_addr,
   input  logic [DATA_W-1:0] rom_data,
   input  logic              hsync_tick,
   input  logic              row_clear,
   output logic              video,
   output logic              pixel_valid
);
   localparam int unsigned BASE_LSB = CODE_BITS + ROW_BITS;
   localparam int unsigned BASE_MSB = ROM_AW - 1;
   localparam int unsigned INV_BIT  = DATA_W - 1;

   generate
      if (ROM_AW >= ADDR_W) begin : g_bad_rom_aw
         $error("glyph address must fit below the fetch window bit");
      end
      if (HALT_BIT >= INV_BIT || HALT_BIT < CODE_BITS) begin : g_bad_halt
         $error("halt bit must sit between code bits and inversion bit");
      end
      if (ROW_BITS < 1 || CODE_BITS < 1 || BASE_BITS < 1) begin : g_bad_fields
         $error("address fields must be non-empty");
      end
   endgenerate

   logic [DATA_W-1:0]   code_q;
   logic                load;
   logic [ROW_BITS-1:0] row_q;

   cfv_fetch_steal #(.DATA_W(DATA_W), .HALT_BIT(HALT_BIT)) u_steal (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_fetch   (bus_fetch),
      .bus_refresh (bus_refresh),
      .window      (bus_addr[ADDR_W-1]),
      .mem_data    (mem_data),
      .cpu_data    (cpu_data),
      .code_q      (code_q),
      .load        (load)
   );

   cfv_row_count #(.ROW_BITS(ROW_BITS)) u_row (
      .clk        (clk),
      .rst_n      (rst_n),
      .hsync_tick (hsync_tick),
      .row_clear  (row_clear),
      .row_q      (row_q)
   );

   assign rom_addr = {bus_addr[BASE_MSB:BASE_LSB], code_q[CODE_BITS-1:0], row_q};

   cfv_shifter #(.PIX_W(DATA_W), .INVERT_EN(INVERT_EN), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (load),
      .glyph       (rom_data),
      .inv         (code_q[INV_BIT]),
      .video       (video),
      .pixel_valid (pixel_valid)
   );

   logic unused_bits;
   assign unused_bits = ^{bus_addr[ADDR_W-2:ROM_AW], bus_addr[BASE_LSB-1:0],
                          code_q[INV_BIT-1:CODE_BITS]};
endmodule

// File: rtl/cfv_serializer_chk.sv
module cfv_serializer_chk #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ROW_BITS  = 3,
   parameter int unsigned HALT_BIT  = 6,
   parameter int unsigned ROM_AW    = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_fetch,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] mem_data,
   input logic [DATA_W-1:0] cpu_data,
   input logic [ROM_AW-1:0] rom_addr,
   input logic              hsync_tick,
   input logic              row_clear,
   input logic              video,
   input logic              pixel_valid
);
   AST_NOP_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_fetch && bus_addr[ADDR_W-1] && !mem_data[HALT_BIT]) |-> cpu_data == '0); // R1
   AST_HALT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_fetch && bus_addr[ADDR_W-1] && mem_data[HALT_BIT]) |-> cpu_data == mem_data); // R2
   AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_fetch && bus_addr[ADDR_W-1]) |-> cpu_data == mem_data); // R3
   AST_ROW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      row_clear |=> rom_addr[ROW_BITS-1:0] == '0); // R5
   AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (hsync_tick && !row_clear) |=>
      rom_addr[ROW_BITS-1:0] == ROW_BITS'($past(rom_addr[ROW_BITS-1:0]) + 1'b1)); // R5
   AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!hsync_tick && !row_clear) |=> $stable(rom_addr[ROW_BITS-1:0])); // R5
   AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      !pixel_valid |-> !video); // R8
endmodule

bind cfv_serializer cfv_serializer_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_BITS(ROW_BITS),
   .HALT_BIT(HALT_BIT), .ROM_AW(ROM_AW)
) u_chk (.*);

// File: tb/cfv_serializer_bench.sv
module cfv_serializer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_fetch = 1'b0;
   logic        bus_refresh = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  mem_data = 8'h5C;
   logic [7:0]  cpu_data;
   logic [12:0] rom_addr;
   logic [7:0]  rom_data;
   logic        hsync_tick = 1'b0;
   logic        row_clear = 1'b0;
   logic        video;
   logic        pixel_valid;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cfv_serializer u_cfv_serializer (.*);

   function automatic logic [7:0] romf(input logic [12:0] a);
      return a[7:0] ^ {a[12:9], a[3:0]} ^ 8'h5A ^ {a[8], 7'b0};
   endfunction

   // glyph ROM answers the address the block presents
   assign rom_data = romf(rom_addr);

   // behavioural reference
   logic [2:0] m_row = '0;
   logic [7:0] m_code = '0;
   bit         m_pend = 1'b0;
   bit         m_q[$];

   function automatic logic [12:0] m_addr();
      return {bus_addr[12:9], m_code[5:0], m_row};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_row = '0; m_pend = 1'b0; m_code = '0; m_q.delete();
      end else begin
         bit         ld;
         logic [7:0] g;
         ld = bus_refresh && m_pend;
         g  = romf(m_addr());
         if (ld) begin
            m_q.delete();
            for (int i = 7; i >= 0; i--) m_q.push_back(g[i] ^ m_code[7]);
         end else if (m_q.size() != 0) begin
            void'(m_q.pop_front());
         end
         if (bus_fetch) begin
            if (bus_addr[15] && !mem_data[6]) begin m_code = mem_data; m_pend = 1'b1; end
            else m_pend = 1'b0;
         end else if (ld) m_pend = 1'b0;
         if (row_clear) m_row = '0;
         else if (hsync_tick) m_row = m_row + 3'd1;
      end
   end

   task automatic check_now();
      logic [7:0] exp_d;
      logic       exp_v, exp_pv;
      exp_pv = (m_q.size() != 0);
      exp_v  = exp_pv ? m_q[0] : 1'b0;
      exp_d  = (bus_fetch && bus_addr[15] && !mem_data[6]) ? 8'h00 : mem_data;
      vectors++;
      if (cpu_data !== exp_d) begin
         fails++;
         if (bus_fetch && bus_addr[15] && !mem_data[6])
            $display("FAIL R1 cpu_data act=%h exp=%h", cpu_data, exp_d);
         else if (bus_fetch && bus_addr[15])
            $display("FAIL R2 cpu_data act=%h exp=%h", cpu_data, exp_d);
         else
            $display("FAIL R3 cpu_data act=%h exp=%h", cpu_data, exp_d);
      end
      vectors++;
      if (pixel_valid !== exp_pv) begin
         fails++;
         $display("FAIL %s pixel_valid act=%b exp=%b", !rst_n ? "R10" : "R6", pixel_valid, exp_pv);
      end
      vectors++;
      if (video !== exp_v) begin
         fails++;
         $display("FAIL %s video act=%b exp=%b", exp_pv ? "R7" : "R8", video, exp_v);
      end
      if (bus_refresh && m_pend) begin
         vectors++;
         if (rom_addr !== m_addr()) begin
            fails++;
            $display("FAIL R4 rom_addr act=%h exp=%h (row field R5)", rom_addr, m_addr());
         end
      end
   endtask

   task automatic step(input bit f, input bit r, input logic [15:0] a, input logic [7:0] d,
                       input bit hs = 1'b0, input bit rc = 1'b0);
      bus_fetch = f; bus_refresh = r; bus_addr = a; mem_data = d;
      hsync_tick = hs; row_clear = rc;
      #4;
      check_now();
      @(negedge clk);
   endtask

   // one character slot: four pixel clocks of fetch, four of refresh
   task automatic slot(input logic [15:0] a, input logic [7:0] d, input logic [7:0] ireg,
                       input bit do_refresh = 1'b1);
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, a, d);
      for (int i = 0; i < 4; i++) step(1'b0, do_refresh, {ireg, 8'(i + 3)}, 8'hE1);
   endtask

   task automatic idle(input int n, input bit hs = 1'b0, input bit rc = 1'b0);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h4321, 8'h2B, hs && i == 0, rc && i == 0);
   endtask

   initial begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 16'h0000, 8'h00); // R10 reset state
      rst_n = 1'b1;
      idle(6);                                                        // R8
      // R1 R4 R6 R7: assorted codes on row 0
      slot(16'h8100, 8'h00, 8'h1E);
      slot(16'h8101, 8'h3F, 8'h1E);
      slot(16'h8102, 8'h85, 8'h1E);
      slot(16'h8103, 8'hBF, 8'h02);
      slot(16'h8104, 8'h2A, 8'h1E);
      slot(16'h8105, 8'h76, 8'h1E);                                   // R2 halt
      idle(10);
      slot(16'h0105, 8'h12, 8'h1E);                                   // R3 lower half
      for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 16'h8200, 8'h11);  // R3 plain read
      // R9: captured, then a lower fetch drops it
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 16'h8300, 8'h21);
      slot(16'h0300, 8'h33, 8'h1E);
      // R9: captured, no refresh, then halt fetch drops it
      slot(16'h8301, 8'h14, 8'h1E, 1'b0);
      slot(16'h8302, 8'h7F, 8'h1E);
      // R9: long refresh loads only once
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 16'h8303, 8'h09);
      for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 16'h1E07, 8'h00);
      // R5: ten lines with hsync between, wrap past 7
      for (int ln = 0; ln < 10; ln++) begin
         idle(3, 1'b1, 1'b0);
         for (int k = 0; k < 6; k++)
            slot({8'h84, 8'(k)}, 8'((ln * 7 + k) % 64) | (k[0] ? 8'h80 : 8'h00), 8'h1E);
         slot(16'h8406, 8'h76, 8'h1E);
      end
      // R5: clear with simultaneous hsync takes priority
      idle(3, 1'b1, 1'b1);
      slot(16'h8500, 8'h0B, 8'h1E);
      idle(3, 1'b1, 1'b0);
      slot(16'h8501, 8'h8C, 8'h1E);
      idle(12);
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule